// File: doc/BRIEF.md
# Private Interrupt State Bank with Security Filtering

This block keeps the live state of the 32 private interrupts of one processor: 16 software-generated (IDs 0 to 15) and 16 peripheral (IDs 16 to 31). For every interrupt it stores an enable bit, a pending bit, an active bit, a group bit, a group modifier bit, an 8-bit priority and, for peripheral IDs, a trigger configuration bit. Each software-generated ID also has a 2-bit non-secure access field. Software reaches this state through a flat word-addressed register port. Each access carries a secure flag. A global `sec_disable` input collapses the security model to two groups.

Each access is filtered per interrupt. When security is on, a non-secure access sees and changes only the interrupts whose resolved group is non-secure Group 1. It also sees their priorities through a halved, shifted view. Peripheral assert lines and software-generated requests set pending bits. Software requests pass through group and access gating first. An acknowledge port and a deactivate port move interrupts between the pending and active states. The resolved groups, enables, pending and active bits go out to the downstream priority selection logic. A one-cycle update pulse tells that logic to rescan.

Top module: `irq_state_bank`

## Requirements
- R1: `irq_grp[2i+1:2i]` gives the resolved group of ID i, encoded 0 = Group 0, 1 = non-secure Group 1, 2 = secure Group 1. With `sec_disable` high, group bit 0 gives 0 and group bit 1 gives 1. With security on, a modifier/group pair of 0/0 gives 0, 0/1 gives 1, 1/0 gives 2 and 1/1 gives 1.
- R2: Enable, pending and active each have a set word and a clear word. The set addresses are 0x01, 0x03 and 0x05, and the clear addresses are 0x02, 0x04 and 0x06. Bit i of a word maps to ID i. Writing 1 sets or clears that bit, and writing 0 leaves it unchanged. Both words of a pair read back the current state.
- R3: With security on and `reg_secure` low, an interrupt whose resolved group is not 1 reads as zero in the enable, pending, active, trigger and priority words, and writes to it are ignored.
- R4: With security on, a non-secure access to a group-1 interrupt reads the priority as (stored << 1) truncated to 8 bits. A write from such an access stores 0x80 | (written >> 1). Secure accesses, and all accesses with `sec_disable` high, read and write the byte unchanged.
- R5: Priorities live at word addresses 0x10 to 0x17. Byte lane l of word w holds ID 4w+l. A lane is written only when `reg_be[l]` is high.
- R6: Trigger configuration uses bit 2k+1 of a word: 1 means edge and 0 means level. The software word at 0x07 always reads that bit as 1 for each visible ID and ignores writes. The peripheral word at 0x08 holds PPI k (ID 16+k) at bit 2k+1 and is writable.
- R7: The group word (0x00) reads zero and ignores writes from non-secure accesses when security is on. The modifier word (0x09) and the access word (0x0A, 2 bits per software ID, ID k at bits 2k+1:2k) are reachable only from secure accesses with security on. In all other cases they read zero and ignore writes.
- R8: A software request for group 2 aimed at a group-0 ID is treated as a group-0 request. A group-0 request aimed at an ID whose group is not 0 is dropped. A request group of 3 is dropped.
- R9: With security on, a request with `sgi_ns` high is dropped for a group-0 ID whose access field is below 1. It is also dropped for a group-2 ID whose access field is below 2.
- R10: After reset, all group, modifier, enable, pending, active, priority, access and peripheral trigger bits are zero, and `update_req` is low.
- R11: An acknowledge clears the pending bit of `ack_id` and sets its active bit. A deactivate clears the active bit of `deact_id`.
- R12: `ppi_assert` bit i sets pending for IDs 16 to 31 only. Bits 0 to 15 have no effect.
- R13: Any cycle that sets at least one pending bit, from software, a peripheral or a software request, drives `update_req` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | Security model disabled (two groups only) |
| reg_addr | input | 5 | Register word address |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte lane strobes (used by priority words) |
| reg_secure | input | 1 | Access is secure |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| ppi_assert | input | 32 | Peripheral assert pulses, bit per ID |
| sgi_req | input | 1 | Software-generated interrupt request |
| sgi_id | input | 4 | Target software interrupt ID |
| sgi_grp | input | 2 | Requested group (0, 1, 2) |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 5 | ID being acknowledged |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | 5 | ID being deactivated |
| irq_grp | output | 64 | Resolved group, 2 bits per ID |
| irq_en | output | 32 | Enable bits |
| irq_pend | output | 32 | Pending bits |
| irq_act | output | 32 | Active bits |
| update_req | output | 1 | Rescan request pulse |

## Verification
The assertions check on every cycle the rules that are visible at the ports. With security disabled, no ID resolves to secure Group 1. An acknowledge leaves its ID active and not pending. Every new pending bit comes with an update pulse. A non-secure enable write leaves hidden IDs untouched. The control words read zero for a non-secure access, and the software trigger word always reads edge. A group-0 request aimed at another group never sets a pending bit. The bench scenarios cover the behaviour that needs a sequence of writes to observe. These include all eight modifier/group/security combinations and the full sweep of software request gating over group, access field, origin and requested group. They also include the shifted priority view across a range of byte values, the byte strobes and the read-back of set and clear words.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam logic [1:0] GRP_G0   = 2'd0;
  localparam logic [1:0] GRP_G1NS = 2'd1;
  localparam logic [1:0] GRP_G1S  = 2'd2;

  localparam logic [4:0] A_GROUP    = 5'h00;
  localparam logic [4:0] A_SET_EN   = 5'h01;
  localparam logic [4:0] A_CLR_EN   = 5'h02;
  localparam logic [4:0] A_SET_PEND = 5'h03;
  localparam logic [4:0] A_CLR_PEND = 5'h04;
  localparam logic [4:0] A_SET_ACT  = 5'h05;
  localparam logic [4:0] A_CLR_ACT  = 5'h06;
  localparam logic [4:0] A_CFG_SGI  = 5'h07;
  localparam logic [4:0] A_CFG_PPI  = 5'h08;
  localparam logic [4:0] A_GRPMOD   = 5'h09;
  localparam logic [4:0] A_NSACC    = 5'h0A;
  localparam logic [1:0] A_PRIO_HI  = 2'b10;

  function automatic logic [1:0] resolve_grp(logic sdis, logic mod, logic grp);
    if (grp) return GRP_G1NS;
    if (sdis || !mod) return GRP_G0;
    return GRP_G1S;
  endfunction

  function automatic logic [7:0] prio_ns_rd(logic [7:0] stored);
    return {stored[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] prio_ns_wr(logic [7:0] wr);
    return {1'b1, wr[7:1]};
  endfunction

  function automatic logic sgi_accept(logic [1:0] tgt, logic [1:0] req, logic ns,
                                      logic sdis, logic [1:0] acc);
    logic [1:0] eff;
    logic       ok;
    eff = (tgt == GRP_G0 && req == GRP_G1S) ? GRP_G0 : req;
    ok  = (req != 2'b11);
    if (eff == GRP_G0 && tgt != GRP_G0) ok = 1'b0;
    if (ns && !sdis) begin
      if (tgt == GRP_G0 && acc < 2'd1) ok = 1'b0;
      if (tgt == GRP_G1S && acc < 2'd2) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/irq_grp_resolve.sv
module irq_grp_resolve
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_disable,
  input  logic               reg_secure,
  input  logic [NUM_IRQ-1:0] grp_bit,
  input  logic [NUM_IRQ-1:0] mod_bit,
  output logic [1:0]         grp_res [NUM_IRQ],
  output logic [NUM_IRQ-1:0] ns_vis
);

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
    assign grp_res[gi] = resolve_grp(sec_disable, mod_bit[gi], grp_bit[gi]);
    // an access may touch this ID: secure, security off, or NS group 1
    assign ns_vis[gi]  = sec_disable | reg_secure | (grp_res[gi] == GRP_G1NS);

    AST_SDIS_NO_G1S: assert property (@(posedge clk) disable iff (!rst_n)
      sec_disable |-> (grp_res[gi] != GRP_G1S)); // R1
  end

endmodule

// File: rtl/irq_sgi_gate.sv
module irq_sgi_gate
  import irq_bank_pkg::*;
#(
  parameter  int NUM_SGI  = 16,
  localparam int SGI_ID_W = $clog2(NUM_SGI)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_disable,
  input  logic                sgi_req,
  input  logic [SGI_ID_W-1:0] sgi_id,
  input  logic [1:0]          sgi_grp,
  input  logic                sgi_ns,
  input  logic [1:0]          tgt_grp [NUM_SGI],
  input  logic [1:0]          ns_acc  [NUM_SGI],
  output logic [NUM_SGI-1:0]  sgi_set
);

  logic sgi_accepted;

  always_comb begin
    sgi_accepted = sgi_req &&
                   sgi_accept(tgt_grp[sgi_id], sgi_grp, sgi_ns, sec_disable, ns_acc[sgi_id]);
    sgi_set = '0;
    if (sgi_accepted) sgi_set[sgi_id] = 1'b1;
  end

  AST_SGI_G0_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_req && sgi_grp == GRP_G0 && tgt_grp[sgi_id] != GRP_G0) |-> (sgi_set == '0)); // R8

  AST_SGI_NSACC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_req && sgi_ns && !sec_disable && tgt_grp[sgi_id] == GRP_G1S &&
     ns_acc[sgi_id] < 2'd2) |-> (sgi_set == '0)); // R9

endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import irq_bank_pkg::*;
#(
  parameter  int NUM_SGI = 16,
  parameter  int NUM_PPI = 16,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_disable,
  input  logic               reg_secure,
  input  logic [4:0]         reg_addr,
  input  logic [NUM_IRQ-1:0] ns_vis,
  input  logic [NUM_IRQ-1:0] grp_bit,
  input  logic [NUM_IRQ-1:0] mod_bit,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] act,
  input  logic [NUM_PPI-1:0] cfg_ppi,
  input  logic [1:0]         ns_acc [NUM_SGI],
  input  logic [7:0]         prio   [NUM_IRQ],
  output logic [31:0]        reg_rdata
);

  logic priv_ok;
  logic ctl_ok;
  int   pid;

  assign priv_ok = sec_disable | reg_secure;
  assign ctl_ok  = !sec_disable && reg_secure;

  always_comb begin
    reg_rdata = '0;
    pid = 0;
    case (reg_addr)
      A_GROUP:              if (priv_ok) reg_rdata[NUM_IRQ-1:0] = grp_bit;
      A_SET_EN,   A_CLR_EN:   reg_rdata[NUM_IRQ-1:0] = en & ns_vis;
      A_SET_PEND, A_CLR_PEND: reg_rdata[NUM_IRQ-1:0] = pend & ns_vis;
      A_SET_ACT,  A_CLR_ACT:  reg_rdata[NUM_IRQ-1:0] = act & ns_vis;
      A_CFG_SGI: for (int k = 0; k < NUM_SGI; k++) reg_rdata[2*k+1] = ns_vis[k];
      A_CFG_PPI: for (int k = 0; k < NUM_PPI; k++)
                   reg_rdata[2*k+1] = cfg_ppi[k] & ns_vis[NUM_SGI+k];
      A_GRPMOD:             if (ctl_ok) reg_rdata[NUM_IRQ-1:0] = mod_bit;
      A_NSACC:              if (ctl_ok) for (int k = 0; k < NUM_SGI; k++)
                              reg_rdata[2*k +: 2] = ns_acc[k];
      default: begin
        if (reg_addr[4:3] == A_PRIO_HI) begin
          for (int l = 0; l < 4; l++) begin
            pid = 4 * int'(reg_addr[2:0]) + l;
            if (pid < NUM_IRQ && ns_vis[pid[ID_W-1:0]])
              reg_rdata[8*l +: 8] = priv_ok ? prio[pid[ID_W-1:0]]
                                            : prio_ns_rd(prio[pid[ID_W-1:0]]);
          end
        end
      end
    endcase
  end

  AST_CTL_NS_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_disable && !reg_secure &&
     (reg_addr == A_GROUP || reg_addr == A_GRPMOD || reg_addr == A_NSACC))
    |-> (reg_rdata == 32'h0)); // R7

  AST_CFG_SGI_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_secure && reg_addr == A_CFG_SGI)
    |-> (reg_rdata[2*NUM_SGI-1:0] == {NUM_SGI{2'b10}})); // R6

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter  int NUM_SGI  = 16,
  parameter  int NUM_PPI  = 16,
  localparam int NUM_IRQ  = NUM_SGI + NUM_PPI,
  localparam int ID_W     = $clog2(NUM_IRQ),
  localparam int SGI_ID_W = $clog2(NUM_SGI)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_disable,
  input  logic [4:0]           reg_addr,
  input  logic                 reg_wr_en,
  input  logic [31:0]          reg_wdata,
  input  logic [3:0]           reg_be,
  input  logic                 reg_secure,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_IRQ-1:0]   ppi_assert,
  input  logic                 sgi_req,
  input  logic [SGI_ID_W-1:0]  sgi_id,
  input  logic [1:0]           sgi_grp,
  input  logic                 sgi_ns,
  input  logic                 ack_valid,
  input  logic [ID_W-1:0]      ack_id,
  input  logic                 deact_valid,
  input  logic [ID_W-1:0]      deact_id,
  output logic [2*NUM_IRQ-1:0] irq_grp,
  output logic [NUM_IRQ-1:0]   irq_en,
  output logic [NUM_IRQ-1:0]   irq_pend,
  output logic [NUM_IRQ-1:0]   irq_act,
  output logic                 update_req
);

  localparam logic [NUM_IRQ-1:0] PPI_MASK = {{NUM_PPI{1'b1}}, {NUM_SGI{1'b0}}};

  // stored state
  logic [NUM_IRQ-1:0] grp_bit, mod_bit, en_q, pend_q, act_q;
  logic [NUM_PPI-1:0] cfg_ppi;
  logic [1:0]         ns_acc [NUM_SGI];
  logic [7:0]         prio   [NUM_IRQ];

  // resolved view
  logic [1:0]         grp_res [NUM_IRQ];
  logic [1:0]         sgi_tgt [NUM_SGI];
  logic [NUM_IRQ-1:0] ns_vis;
  logic [NUM_SGI-1:0] sgi_set;

  // named write events
  logic               priv_ok, ctl_ok;
  logic [NUM_IRQ-1:0] wbits;
  logic [NUM_IRQ-1:0] set_en_m, clr_en_m, set_pend_m, clr_pend_m, set_act_m, clr_act_m;
  logic [NUM_IRQ-1:0] ack_m, deact_m, pend_set;
  logic [NUM_IRQ-1:0] en_n, pend_n, act_n;
  logic               grp_we, mod_we, acc_we, cfgp_we;
  logic [NUM_IRQ-1:0] prio_we;
  logic [7:0]         prio_wval [NUM_IRQ];

  irq_grp_resolve #(.NUM_IRQ(NUM_IRQ)) u_resolve (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .reg_secure(reg_secure),
    .grp_bit(grp_bit), .mod_bit(mod_bit), .grp_res(grp_res), .ns_vis(ns_vis)
  );

  for (genvar gs = 0; gs < NUM_SGI; gs++) begin : g_sgi_tgt
    assign sgi_tgt[gs] = grp_res[gs];
  end

  irq_sgi_gate #(.NUM_SGI(NUM_SGI)) u_sgi_gate (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .sgi_req(sgi_req),
    .sgi_id(sgi_id), .sgi_grp(sgi_grp), .sgi_ns(sgi_ns), .tgt_grp(sgi_tgt),
    .ns_acc(ns_acc), .sgi_set(sgi_set)
  );

  irq_reg_read #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_read (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .reg_secure(reg_secure),
    .reg_addr(reg_addr), .ns_vis(ns_vis), .grp_bit(grp_bit), .mod_bit(mod_bit),
    .en(en_q), .pend(pend_q), .act(act_q), .cfg_ppi(cfg_ppi), .ns_acc(ns_acc),
    .prio(prio), .reg_rdata(reg_rdata)
  );

  assign priv_ok = sec_disable | reg_secure;
  assign ctl_ok  = !sec_disable && reg_secure;
  assign wbits   = reg_wdata[NUM_IRQ-1:0] & ns_vis;

  always_comb begin
    set_en_m   = (reg_wr_en && reg_addr == A_SET_EN)   ? wbits : '0;
    clr_en_m   = (reg_wr_en && reg_addr == A_CLR_EN)   ? wbits : '0;
    set_pend_m = (reg_wr_en && reg_addr == A_SET_PEND) ? wbits : '0;
    clr_pend_m = (reg_wr_en && reg_addr == A_CLR_PEND) ? wbits : '0;
    set_act_m  = (reg_wr_en && reg_addr == A_SET_ACT)  ? wbits : '0;
    clr_act_m  = (reg_wr_en && reg_addr == A_CLR_ACT)  ? wbits : '0;
    grp_we     = reg_wr_en && reg_addr == A_GROUP  && priv_ok;
    mod_we     = reg_wr_en && reg_addr == A_GRPMOD && ctl_ok;
    acc_we     = reg_wr_en && reg_addr == A_NSACC  && ctl_ok;
    cfgp_we    = reg_wr_en && reg_addr == A_CFG_PPI;
    ack_m      = ack_valid   ? (NUM_IRQ'(1) << ack_id)   : '0;
    deact_m    = deact_valid ? (NUM_IRQ'(1) << deact_id) : '0;
    pend_set   = set_pend_m | (ppi_assert & PPI_MASK) | {{NUM_PPI{1'b0}}, sgi_set};
    en_n       = (en_q | set_en_m) & ~clr_en_m;
    // acknowledge has the last word on pending, deactivate on active
    pend_n     = (pend_q | pend_set) & ~clr_pend_m & ~ack_m;
    act_n      = (act_q | set_act_m | ack_m) & ~clr_act_m & ~deact_m;
  end

  for (genvar gp = 0; gp < NUM_IRQ; gp++) begin : g_prio
    assign prio_we[gp] = reg_wr_en && reg_addr[4:3] == A_PRIO_HI &&
                         reg_addr[2:0] == 3'(gp / 4) && reg_be[gp % 4] && ns_vis[gp];
    assign prio_wval[gp] = priv_ok ? reg_wdata[8*(gp%4) +: 8]
                                   : prio_ns_wr(reg_wdata[8*(gp%4) +: 8]);
    assign irq_grp[2*gp +: 2] = grp_res[gp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_bit    <= '0;
      mod_bit    <= '0;
      en_q       <= '0;
      pend_q     <= '0;
      act_q      <= '0;
      cfg_ppi    <= '0;
      update_req <= 1'b0;
      for (int k = 0; k < NUM_SGI; k++) ns_acc[k] <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio[i] <= '0;
    end else begin
      if (grp_we) grp_bit <= reg_wdata[NUM_IRQ-1:0];
      if (mod_we) mod_bit <= reg_wdata[NUM_IRQ-1:0];
      if (acc_we) for (int k = 0; k < NUM_SGI; k++) ns_acc[k] <= reg_wdata[2*k +: 2];
      for (int k = 0; k < NUM_PPI; k++)
        if (cfgp_we && ns_vis[NUM_SGI+k]) cfg_ppi[k] <= reg_wdata[2*k+1];
      for (int i = 0; i < NUM_IRQ; i++)
        if (prio_we[i]) prio[i] <= prio_wval[i];
      en_q       <= en_n;
      pend_q     <= pend_n;
      act_q      <= act_n;
      update_req <= |pend_set;
    end
  end

  assign irq_en   = en_q;
  assign irq_pend = pend_q;
  assign irq_act  = act_q;

  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !deact_valid && !reg_wr_en)
    |=> (irq_act[$past(ack_id)] && !irq_pend[$past(ack_id)])); // R11

  AST_PEND_RISE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_pend & ~$past(irq_pend))) |-> update_req); // R13

  AST_NS_HIDDEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_secure && !sec_disable &&
     (reg_addr == A_SET_EN || reg_addr == A_CLR_EN))
    |=> (((irq_en ^ $past(irq_en)) & ~$past(ns_vis)) == '0)); // R3

endmodule

// File: tb/irq_state_bank_tb.sv
`timescale 1ns/1ps
module irq_state_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_disable = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = 4'hF;
  logic        reg_secure = 1'b1;
  logic [31:0] reg_rdata;
  logic [31:0] ppi_assert = '0;
  logic        sgi_req = 1'b0;
  logic [3:0]  sgi_id = '0;
  logic [1:0]  sgi_grp = '0;
  logic        sgi_ns = 1'b0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_id = '0;
  logic        deact_valid = 1'b0;
  logic [4:0]  deact_id = '0;
  logic [63:0] irq_grp;
  logic [31:0] irq_en, irq_pend, irq_act;
  logic        update_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_state_bank u_dut (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_secure(reg_secure), .reg_rdata(reg_rdata), .ppi_assert(ppi_assert),
    .sgi_req(sgi_req), .sgi_id(sgi_id), .sgi_grp(sgi_grp), .sgi_ns(sgi_ns),
    .ack_valid(ack_valid), .ack_id(ack_id), .deact_valid(deact_valid),
    .deact_id(deact_id), .irq_grp(irq_grp), .irq_en(irq_en), .irq_pend(irq_pend),
    .irq_act(irq_act), .update_req(update_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic sec,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_secure = sec; reg_be = be; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic sec,
                       input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a; reg_secure = sec; reg_wr_en = 1'b0;
    #1 chk(tag, reg_rdata, exp);
  endtask

  // independent statement of the request gating rules
  function automatic logic exp_sgi(int ig, int rq, int ns, int acc);
    int need;
    if (rq == 3) return 1'b0;
    if (rq == 0 && ig != 0) return 1'b0;
    need = (ig == 0) ? 1 : ((ig == 2) ? 2 : 0);
    if (ns != 0 && acc < need) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state, R6 software trigger word
    rdchk("R10 group", 5'h00, 1'b1, 32'h0);
    rdchk("R10 enable", 5'h01, 1'b1, 32'h0);
    rdchk("R10 pending", 5'h03, 1'b1, 32'h0);
    rdchk("R10 active", 5'h05, 1'b1, 32'h0);
    rdchk("R10 modifier", 5'h09, 1'b1, 32'h0);
    rdchk("R10 access", 5'h0A, 1'b1, 32'h0);
    rdchk("R10 ppi cfg", 5'h08, 1'b1, 32'h0);
    for (int w = 0; w < 8; w++) rdchk("R10 priority", 5'(16 + w), 1'b1, 32'h0);
    rdchk("R6 sgi cfg edge", 5'h07, 1'b1, 32'hAAAAAAAA);
    chk("R10 update_req", {31'h0, update_req}, 32'h0);

    // R2 set/clear pairs
    wr(5'h01, 32'h000000F0, 1'b1);
    wr(5'h02, 32'h00000030, 1'b1);
    wr(5'h02, 32'h00000000, 1'b1);
    rdchk("R2 enable via set", 5'h01, 1'b1, 32'h000000C0);
    rdchk("R2 enable via clear", 5'h02, 1'b1, 32'h000000C0);
    wr(5'h05, 32'h00FF00FF, 1'b1);
    wr(5'h06, 32'h000F000F, 1'b1);
    rdchk("R2 active", 5'h06, 1'b1, 32'h00F000F0);
    wr(5'h03, 32'h80000001, 1'b1);
    chk("R13 pulse after set-pending", {31'h0, update_req}, 32'h1);
    @(negedge clk);
    chk("R13 pulse one cycle", {31'h0, update_req}, 32'h0);
    rdchk("R2 pending", 5'h04, 1'b1, 32'h80000001);
    wr(5'h04, 32'h80000001, 1'b1);
    rdchk("R2 pending cleared", 5'h03, 1'b1, 32'h0);
    wr(5'h02, 32'hFFFFFFFF, 1'b1);
    wr(5'h06, 32'hFFFFFFFF, 1'b1);

    // R1 group resolution sweep on ID 5
    for (int sd = 0; sd < 2; sd++)
      for (int m = 0; m < 2; m++)
        for (int g = 0; g < 2; g++) begin
          sec_disable = 1'b0;
          wr(5'h09, 32'(m) << 5, 1'b1);
          wr(5'h00, 32'(g) << 5, 1'b1);
          @(negedge clk);
          sec_disable = sd[0];
          #1 chk("R1 resolved group", {30'h0, irq_grp[11:10]},
                 32'((g == 1) ? 1 : ((sd == 0 && m == 1) ? 2 : 0)));
        end
    sec_disable = 1'b0;
    wr(5'h0A, 32'h0000000C, 1'b1);
    rdchk("R7 access readback", 5'h0A, 1'b1, 32'h0000000C);
    rdchk("R7 access ns raz", 5'h0A, 1'b0, 32'h0);
    @(negedge clk); sec_disable = 1'b1;
    rdchk("R7 modifier raz when disabled", 5'h09, 1'b1, 32'h0);
    rdchk("R7 access raz when disabled", 5'h0A, 1'b1, 32'h0);
    sec_disable = 1'b0;
    wr(5'h09, 32'h0, 1'b1);
    wr(5'h0A, 32'h0, 1'b1);
    wr(5'h00, 32'h0, 1'b1);

    // R3 per-interrupt non-secure filtering
    wr(5'h00, 32'h0000FFFF, 1'b1);
    wr(5'h01, 32'hFFFFFFFF, 1'b0);
    rdchk("R3 ns view enable", 5'h01, 1'b0, 32'h0000FFFF);
    rdchk("R3 ns set ignored on hidden", 5'h02, 1'b1, 32'h0000FFFF);
    wr(5'h01, 32'hFFFFFFFF, 1'b1);
    wr(5'h02, 32'hFFFFFFFF, 1'b0);
    rdchk("R3 ns clear ignored on hidden", 5'h01, 1'b1, 32'hFFFF0000);
    wr(5'h00, 32'h00FF00FF, 1'b1);
    rdchk("R3 ns masked read", 5'h01, 1'b0, 32'h00FF0000);
    rdchk("R3 ns sgi cfg", 5'h07, 1'b0, 32'h0000AAAA);
    @(negedge clk); sec_disable = 1'b1;
    rdchk("R3 no filter when disabled", 5'h01, 1'b0, 32'hFFFF0000);
    sec_disable = 1'b0;
    rdchk("R7 ns group raz", 5'h00, 1'b0, 32'h0);
    wr(5'h00, 32'h0, 1'b0);
    rdchk("R7 ns group write ignored", 5'h00, 1'b1, 32'h00FF00FF);
    wr(5'h02, 32'hFFFFFFFF, 1'b1);

    // R6 trigger configuration
    wr(5'h08, 32'h0000000A, 1'b1);
    rdchk("R6 ppi cfg", 5'h08, 1'b1, 32'h0000000A);
    wr(5'h07, 32'h0, 1'b1);
    rdchk("R6 sgi cfg fixed", 5'h07, 1'b1, 32'hAAAAAAAA);
    wr(5'h08, 32'hFFFFFFFF, 1'b0);
    rdchk("R3 ns ppi cfg write filtered", 5'h08, 1'b1, 32'h0000AAAA);

    // R4 shifted priority view on ID 20 (word 0x15 lane 0)
    for (int v = 0; v < 256; v += 17) begin
      wr(5'h15, 32'(v), 1'b0, 4'b0001);
      rdchk("R4 secure sees stored", 5'h15, 1'b1, 32'((v / 2) + 128));
      rdchk("R4 ns sees shifted", 5'h15, 1'b0, 32'((v / 2) * 2));
    end
    // R5 byte strobes
    wr(5'h15, 32'h44332211, 1'b1, 4'b0100);
    rdchk("R5 single lane", 5'h15, 1'b1, 32'h003300FF);
    // R3 hidden priority (IDs 24..27 are group 0)
    wr(5'h16, 32'hFFFFFFFF, 1'b0);
    rdchk("R3 ns priority write ignored", 5'h16, 1'b1, 32'h0);
    wr(5'h16, 32'h11223344, 1'b1);
    rdchk("R3 ns priority raz", 5'h16, 1'b0, 32'h0);

    // R12 peripheral asserts
    wr(5'h04, 32'hFFFFFFFF, 1'b1);
    @(negedge clk); ppi_assert = 32'hFFFFFFFF;
    @(negedge clk); ppi_assert = 32'h0;
    chk("R12 only peripheral IDs", irq_pend, 32'hFFFF0000);
    chk("R13 pulse on ppi", {31'h0, update_req}, 32'h1);
    wr(5'h04, 32'hFFFFFFFF, 1'b1);
    @(negedge clk); ppi_assert = 32'h0000FFFF;
    @(negedge clk); ppi_assert = 32'h0;
    chk("R12 low bits ignored", irq_pend, 32'h0);
    chk("R13 no pulse", {31'h0, update_req}, 32'h0);

    // R8 / R9 software request sweep on ID 3
    wr(5'h00, 32'h0, 1'b1);
    for (int ig = 0; ig < 3; ig++) begin
      wr(5'h09, (ig == 2) ? 32'h8 : 32'h0, 1'b1);
      wr(5'h00, (ig == 1) ? 32'h8 : 32'h0, 1'b1);
      #1 chk("R1 target group", {30'h0, irq_grp[7:6]}, 32'(ig));
      for (int acc = 0; acc < 4; acc++) begin
        wr(5'h0A, 32'(acc) << 6, 1'b1);
        for (int rq = 0; rq < 4; rq++)
          for (int ns = 0; ns < 2; ns++) begin
            wr(5'h04, 32'h8, 1'b1);
            @(negedge clk);
            sgi_req = 1'b1; sgi_id = 4'd3; sgi_grp = 2'(rq); sgi_ns = ns[0];
            @(negedge clk);
            sgi_req = 1'b0;
            chk("R8 R9 request gating", {31'h0, irq_pend[3]}, 32'(exp_sgi(ig, rq, ns, acc)));
            chk("R13 request pulse", {31'h0, update_req}, 32'(exp_sgi(ig, rq, ns, acc)));
          end
      end
    end
    wr(5'h04, 32'hFFFFFFFF, 1'b1);

    // R11 acknowledge and deactivate
    wr(5'h03, 32'h00000200, 1'b1);
    @(negedge clk); ack_valid = 1'b1; ack_id = 5'd9;
    @(negedge clk); ack_valid = 1'b0;
    chk("R11 ack clears pending", irq_pend, 32'h0);
    chk("R11 ack sets active", irq_act, 32'h00000200);
    @(negedge clk); deact_valid = 1'b1; deact_id = 5'd9;
    @(negedge clk); deact_valid = 1'b0;
    chk("R11 deactivate", irq_act, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule